// File: doc/BRIEF.md
# Time-Division Audio Link Frame Transmitter

This block is the sending half of a controller on a time-division serial audio link. It runs on the link's bit clock. It divides that clock by 256 to mark out frames, and it drives a frame sync line plus one serial data line. Each frame starts with a 16-bit tag slot. Twelve 20-bit data slots follow the tag. In the tag, a frame-valid flag comes first, then one valid flag for each data slot. Any slot whose flag is clear goes out as all zeros, whatever payload was supplied for it.

Payloads and flags arrive on a parallel interface. The block samples them once per frame, on the rising edge that starts the frame. In the cycle before that edge, a request output tells the supplier to present the next frame's contents.

A halt input stops the link to save power. The frame in flight runs to its end. After that, sync and data stay low, and the block keeps its contents. When halt is released, a new frame begins at the tag slot on the next edge.

A small sequencer controls the frame. It has three states:
- PARK: the link is idle. This is the reset state, and the block stays here while halt is held.
- TAG: the tag slot is going out. Sync is high in this state.
- DATA: the twelve data slots are going out.

It has four transitions:
- start: PARK to TAG, when halt is low.
- tag_done: TAG to DATA, after 16 bits.
- wrap: DATA to TAG, at bit 255 when halt is low.
- park: DATA to PARK, at bit 255 when halt is high.

Top module: `tdmtx_top`

## Requirements
- R1: While halt stays low, a new frame starts every 256 bit-clock cycles.
- R2: Sync is high for exactly the 16 cycles of the tag slot and low for the other 240 bits of the frame.
- R3: Bits go out most significant first. Tag bit 15 carries `frame_valid`. Tag bits 14 down to 3 carry `slot_valid[0]` to `slot_valid[11]` (slots 1 to 12). Tag bits 2 to 0 are zero. Slot k (1 to 12) carries `slot_data[20k-1:20(k-1)]`.
- R4: Every bit of a slot whose valid flag is 0 is driven as 0, even when its payload is nonzero.
- R5: Sync and data change only on the rising edge. The first tag bit appears on the same edge that raises sync.
- R6: `frame_next` is high in the cycle just before each frame start. The inputs are sampled on that start edge, and input changes later in the frame do not alter the frame being sent.
- R7: When halt is raised mid-frame, that frame completes unchanged. After it ends, sync, data and `frame_next` stay low for as long as halt is held.
- R8: Once halt is released, the first rising edge starts a new frame at the tag slot, built from the inputs present at that edge.
- R9: While reset is active, sync and data are low. After reset is released with halt low, the first edge starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| halt | input | 1 | Power-save stop, applied at the next frame boundary |
| frame_valid | input | 1 | Frame-valid flag for tag bit 15 |
| slot_valid | input | 12 | Valid flag for each data slot; bit 0 is slot 1 |
| slot_data | input | 240 | Payloads, 20 bits per slot; slot 1 in the lowest bits |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdo | output | 1 | Serial data, MSB first |
| frame_next | output | 1 | Requests next frame's inputs; they are sampled on the following edge |

## Verification
The sequencer state and the bit counter are visible at the pins within one frame:
- A wrong bit count moves the falling edge of sync or the next rising edge away from the 16-bit and 256-bit positions. This shows within the first frame.
- A wrong state choice at the boundary shows on the very next edge. Either a frame starts while halt is held, or sync stays low after halt is released.

The shift register and the stuffing logic show as a mismatched bit at a known position in the captured frame. This shows no later than the end of the frame that was loaded.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_PARK = 2'd0,   // idle: reset or halted, outputs low
        ST_TAG  = 2'd1,   // tag slot on the wire, sync high
        ST_DATA = 2'd2    // data slots on the wire
    } seq_state_t;

endpackage

// File: rtl/tdmtx_seq.sv
module tdmtx_seq
    import tdmtx_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int FRAME_LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    output logic sync,
    output logic start,
    output logic stop,
    output logic run
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] TAG_END  = CW'(TAG_W - 1);

    seq_state_t state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // State register and bit counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PARK;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Next-state logic and the start/stop strobes.
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        start   = 1'b0;
        stop    = 1'b0;
        unique case (state)
            ST_PARK: begin
                if (!halt) begin              // start
                    nxt     = ST_TAG;
                    cnt_nxt = '0;
                    start   = 1'b1;
                end
            end
            ST_TAG: begin
                cnt_nxt = cnt + CW'(1);
                if (cnt == TAG_END) nxt = ST_DATA;   // tag_done
            end
            ST_DATA: begin
                if (cnt == LAST_BIT) begin
                    cnt_nxt = '0;
                    if (halt) begin           // park
                        nxt  = ST_PARK;
                        stop = 1'b1;
                    end else begin            // wrap
                        nxt   = ST_TAG;
                        start = 1'b1;
                    end
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            default: begin
                nxt     = ST_PARK;
                cnt_nxt = '0;
            end
        endcase
    end

    assign run = (state != ST_PARK);

    // Registered sync output, high while the tag slot is on the wire.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 1'b0;
        else        sync <= (nxt == ST_TAG);
    end

endmodule

// File: rtl/tdmtx_assemble.sv
module tdmtx_assemble #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int N_SLOTS   = 12,
    parameter int FRAME_LEN = TAG_W + N_SLOTS * SLOT_W
) (
    input  logic                        frame_valid,
    input  logic [N_SLOTS-1:0]          slot_valid,
    input  logic [N_SLOTS*SLOT_W-1:0]   slot_data,
    output logic [FRAME_LEN-1:0]        frame
);
    localparam int BODY_W = N_SLOTS * SLOT_W;

    logic [TAG_W-1:0]  tag;
    logic [BODY_W-1:0] body;

    // Tag word: frame flag on top, then one flag per slot, zeros below.
    always_comb begin
        tag = '0;
        tag[TAG_W-1] = frame_valid;
        for (int k = 0; k < N_SLOTS; k++) begin
            tag[TAG_W-2-k] = slot_valid[k];
        end
    end

    // Slot 1 sits right after the tag; invalid slots are zero-stuffed.
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign body[(N_SLOTS-1-g)*SLOT_W +: SLOT_W] =
            slot_valid[g] ? slot_data[g*SLOT_W +: SLOT_W] : '0;
    end

    assign frame = {tag, body};

endmodule

// File: rtl/tdmtx_shift.sv
module tdmtx_shift #(
    parameter int FRAME_LEN = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 stop,
    input  logic                 run,
    input  logic [FRAME_LEN-1:0] frame,
    output logic                 sdo
);
    logic [FRAME_LEN-1:0] sh;

    // Load drives the first bit at once; later bits shift out MSB first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else if (load) begin
            sdo <= frame[FRAME_LEN-1];
            sh  <= {frame[FRAME_LEN-2:0], 1'b0};
        end else if (stop) begin
            sdo <= 1'b0;
        end else if (run) begin
            sdo <= sh[FRAME_LEN-1];
            sh  <= {sh[FRAME_LEN-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/tdmtx_top.sv
module tdmtx_top #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       halt,
    input  logic                       frame_valid,
    input  logic [N_SLOTS-1:0]         slot_valid,
    input  logic [N_SLOTS*SLOT_W-1:0]  slot_data,
    output logic                       sync,
    output logic                       sdo,
    output logic                       frame_next
);
    localparam int FRAME_LEN = TAG_W + N_SLOTS * SLOT_W;

    logic                 start, stop, run, parked;
    logic [FRAME_LEN-1:0] frame;

    tdmtx_seq #(
        .TAG_W     (TAG_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .sync  (sync),
        .start (start),
        .stop  (stop),
        .run   (run)
    );

    tdmtx_assemble #(
        .TAG_W     (TAG_W),
        .SLOT_W    (SLOT_W),
        .N_SLOTS   (N_SLOTS),
        .FRAME_LEN (FRAME_LEN)
    ) u_asm (
        .frame_valid (frame_valid),
        .slot_valid  (slot_valid),
        .slot_data   (slot_data),
        .frame       (frame)
    );

    tdmtx_shift #(
        .FRAME_LEN (FRAME_LEN)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .stop  (stop),
        .run   (run),
        .frame (frame),
        .sdo   (sdo)
    );

    assign parked     = ~run;
    assign frame_next = start;

endmodule

// File: rtl/tdmtx_chk.sv
module tdmtx_chk #(
    parameter int TAG_W     = 16,
    parameter int FRAME_LEN = 256
) (
    input logic clk,
    input logic rst_n,
    input logic halt,
    input logic frame_valid,
    input logic sync,
    input logic sdo,
    input logic frame_next,
    input logic parked
);
    logic [7:0] hi_len;
    logic [9:0] gap;
    logic       seen_rise;
    logic       seen_park;

    // Bookkeeping for the window checks: sync run length and frame spacing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len    <= '0;
            gap       <= '0;
            seen_rise <= 1'b0;
            seen_park <= 1'b0;
        end else begin
            hi_len <= sync ? hi_len + 8'd1 : 8'd0;
            if (sync && !seen_rise) seen_rise <= 1'b1;
            if (parked) seen_park <= 1'b1;
            if ($rose(sync)) begin
                gap       <= 10'd1;
                seen_park <= 1'b0;
            end else if (gap != 10'h3FF) begin
                gap <= gap + 10'd1;
            end
        end
    end

    // R1: consecutive frame starts are one frame length apart when not halted
    a_r1_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync) && seen_rise && !seen_park) |-> (32'(gap) == FRAME_LEN));

    // R2: sync never stays high longer than the tag slot
    a_r2_sync_max: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> (32'(hi_len) < TAG_W));

    // R2: sync falls only after exactly the tag slot
    a_r2_sync_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync) |-> (32'(hi_len) == TAG_W));

    // R5: the first data bit with sync is the frame-valid flag sampled at start
    a_r5_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> (sdo == $past(frame_valid)));

    // R6: a request is followed by a frame start on the next edge
    a_r6_req_then_start: assert property (@(posedge clk) disable iff (!rst_n)
        frame_next |=> $rose(sync));

    // R7: while parked, the link is silent and no data is requested under halt
    a_r7_park_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> (!sync && !sdo && !(halt && frame_next)));

endmodule

bind tdmtx_top tdmtx_chk #(
    .TAG_W     (TAG_W),
    .FRAME_LEN (FRAME_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .frame_valid (frame_valid),
    .sync        (sync),
    .sdo         (sdo),
    .frame_next  (frame_next),
    .parked      (parked)
);

// File: tb/test_tdmtx_top.sv
`timescale 1ns/1ps
module test_tdmtx_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         halt = 1'b0;
    logic         frame_valid = 1'b0;
    logic [11:0]  slot_valid = '0;
    logic [239:0] slot_data = '0;
    logic         sync, sdo, frame_next;

    int checks = 0;
    int errors = 0;

    localparam logic [255:0] SYNC_MASK = {16'hFFFF, 240'd0};

    // Inputs applied partway through a capture.
    logic         alt_fv;
    logic [11:0]  alt_sv;
    logic [239:0] alt_sd;

    always #2.5 clk = ~clk;

    tdmtx_top i_tdmtx_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt        (halt),
        .frame_valid (frame_valid),
        .slot_valid  (slot_valid),
        .slot_data   (slot_data),
        .sync        (sync),
        .sdo         (sdo),
        .frame_next  (frame_next)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] expect_frame(input logic fv, input logic [11:0] sv,
                                                  input logic [239:0] sd);
        logic [255:0] f;
        f = '0;
        f[255] = fv;
        for (int k = 0; k < 12; k++) begin
            f[254-k] = sv[k];
            if (sv[k]) f[239-20*k -: 20] = sd[20*k +: 20];
        end
        return f;
    endfunction

    function automatic logic [239:0] make_data(input logic [19:0] seed);
        logic [239:0] d;
        for (int k = 0; k < 12; k++) d[20*k +: 20] = 20'((k + 1) * 20'h1F3A7) ^ seed;
        return d;
    endfunction

    // Waits for the next sync rise (sampled at negedges) and records one frame.
    // change_at / halt_at: bit index at which alt inputs are applied / halt raised (-1: never).
    task automatic grab(output logic [255:0] bits, output logic [255:0] syncs,
                        output int waited, output logic fn_prev,
                        input int change_at, input int halt_at);
        logic last;
        last = sync;
        waited = 0;
        fn_prev = 1'b0;
        do begin
            fn_prev = frame_next;
            @(negedge clk);
            waited++;
            if (sync && !last) break;
            last = sync;
        end while (waited < 2000);
        for (int i = 0; i < 256; i++) begin
            bits[255-i]  = sdo;
            syncs[255-i] = sync;
            if (i == change_at) begin
                frame_valid = alt_fv;
                slot_valid  = alt_sv;
                slot_data   = alt_sd;
            end
            if (i == halt_at) halt = 1'b1;
            if (i < 255) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [255:0] b, s, e;
        int w;
        logic fp;
        bit quiet;
        frame_valid = 1'b1;
        slot_valid  = 12'hFFF;
        slot_data   = make_data(20'h5A5A5);
        quiet = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (sync !== 1'b0 || sdo !== 1'b0) quiet = 1'b0;
        end
        chk(quiet, "R9 outputs low in reset", {254'd0, sync, sdo}, 256'd0);
        rst_n = 1'b1;
        e = expect_frame(frame_valid, slot_valid, slot_data);
        grab(b, s, w, fp, -1, -1);
        chk(w == 1, "R9 first frame on first edge after reset", 256'(w), 256'd1);
        chk(b == e, "R3 frame content after reset", b, e);
    endtask

    task automatic t_pattern(input logic fv, input logic [11:0] sv, input logic [19:0] seed,
                             input string req);
        logic [255:0] b, s, e;
        int w;
        logic fp;
        frame_valid = fv;
        slot_valid  = sv;
        slot_data   = make_data(seed);
        e = expect_frame(fv, sv, slot_data);
        grab(b, s, w, fp, -1, -1);
        chk(b == e, req, b, e);
        chk(s == SYNC_MASK, "R2 sync high for tag slot only", s, SYNC_MASK);
        chk(b[255] == fv, "R5 first bit with sync rise", 256'(b[255]), 256'(fv));
        chk(fp == 1'b1, "R6 frame_next before start", 256'(fp), 256'd1);
    endtask

    task automatic t_stuff;
        logic [255:0] b, s, e, mask;
        int w;
        logic fp;
        frame_valid = 1'b1;
        slot_valid  = 12'b1010_0110_1001;
        slot_data   = {240{1'b1}};
        e = expect_frame(1'b1, slot_valid, slot_data);
        mask = '0;
        for (int k = 0; k < 12; k++)
            if (!slot_valid[k]) mask[239-20*k -: 20] = '1;
        grab(b, s, w, fp, -1, -1);
        chk((b & mask) == '0, "R4 invalid slots zero", b & mask, 256'd0);
        chk(b == e, "R3 mixed valid frame", b, e);
        slot_valid = 12'h000;
        frame_valid = 1'b0;
        grab(b, s, w, fp, -1, -1);
        chk(b == '0, "R4 all slots invalid", b, 256'd0);
    endtask

    task automatic t_period;
        logic [255:0] b, s;
        int w;
        logic fp;
        frame_valid = 1'b1;
        slot_valid  = 12'h0F0;
        slot_data   = make_data(20'h13579);
        grab(b, s, w, fp, -1, -1);
        @(negedge clk);
        chk(sync == 1'b1, "R1 next frame 256 cycles later", 256'(sync), 256'd1);
        chk(s == SYNC_MASK, "R1 no early restart", s, SYNC_MASK);
    endtask

    task automatic t_midchange;
        logic [255:0] b, s, e;
        int w;
        logic fp;
        frame_valid = 1'b1;
        slot_valid  = 12'hFFF;
        slot_data   = make_data(20'hABCDE);
        e = expect_frame(frame_valid, slot_valid, slot_data);
        alt_fv = 1'b0;
        alt_sv = 12'h555;
        alt_sd = make_data(20'h0F0F0);
        grab(b, s, w, fp, 100, -1);
        chk(b == e, "R6 mid-frame change ignored", b, e);
        e = expect_frame(alt_fv, alt_sv, alt_sd);
        grab(b, s, w, fp, -1, -1);
        chk(b == e, "R6 change taken at next start", b, e);
    endtask

    task automatic t_halt;
        logic [255:0] b, s, e;
        int w;
        logic fp;
        bit quiet;
        frame_valid = 1'b1;
        slot_valid  = 12'h3C3;
        slot_data   = make_data(20'h24680);
        e = expect_frame(frame_valid, slot_valid, slot_data);
        grab(b, s, w, fp, -1, 50);
        chk(b == e, "R7 halted frame completes", b, e);
        quiet = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sync !== 1'b0 || sdo !== 1'b0 || frame_next !== 1'b0) quiet = 1'b0;
            if (i == 40) begin
                slot_valid = 12'hA5A;
                slot_data  = make_data(20'h77777);
            end
        end
        chk(quiet, "R7 silent while halted", {253'd0, sync, sdo, frame_next}, 256'd0);
        halt = 1'b0;
        e = expect_frame(frame_valid, slot_valid, slot_data);
        grab(b, s, w, fp, -1, -1);
        chk(w == 1, "R8 restart on first edge", 256'(w), 256'd1);
        chk(b == e, "R8 restart frame uses fresh inputs", b, e);
        chk(s == SYNC_MASK, "R8 restart begins with tag slot", s, SYNC_MASK);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pattern(1'b1, 12'hFFF, 20'h12345, "R3 all slots valid");
        t_pattern(1'b1, 12'h801, 20'hFEDCB, "R3 first and last slot");
        t_stuff();
        t_period();
        t_midchange();
        t_halt();
        t_pattern(1'b1, 12'h0FF, 20'h31415, "R3 after halt cycle");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule